// File: doc/BRIEF.md
# Sprite Line Evaluator

This block prepares eight sprite shifter slots for the next logical scanline of a 320x240 display built on a 640x480 video timing. Once the physical horizontal counter of the current line reaches logical column 320, it walks a 64-entry table of 32-bit sprite descriptors held in video memory. It picks the first eight active sprites, in table order, whose 8-row span covers the coming logical line.

For each chosen sprite the block works out which row of the 8x8, 4-bit-per-pixel bitmap is needed, with the row mirrored when the vertical flip flag is set. It reads that single 32-bit row word and strobes it into the next free shifter slot, together with the sprite's horizontal start and horizontal flip flag. Slots left over when the scan ends are loaded with a transparent all-zero line, so nothing from the previous line is shown again. The video memory port is a synchronous read port with an 11-bit word address and one cycle of latency.

Top module: `spr_line_eval`

## Requirements
- R1: A scan starts only when hcnt_i[9:1] becomes 320 (hcnt_i moves into 640 from any other value), and only if no scan is running. Outside a scan there are no VRAM reads and no slot strobes.
- R2: The target logical line is ((vcnt_i + 1) mod 525) >> 1, taken in the cycle the scan starts. vcnt_i = 524 targets line 0.
- R3: Descriptor k is read from word address 1024 + k, in ascending k. Read data is used one cycle after vram_rd_o is high.
- R4: Descriptor fields: vertical start in bits [7:0], horizontal start in [16:8], sprite index in [23:17], vertical flip in bit 24, horizontal flip in bit 25, active in bit 26. Bits [31:27] are ignored.
- R5: A descriptor hits line y when active = 1 and 0 <= y - vstart <= 7.
- R6: Hits go to slots 0, 1, 2 and so on, in table order. The scan stops after the eighth hit, and no later descriptor is read.
- R7: The bitmap row word address is index*8 + r, where r = y - vstart, or 7 - r when vertical flip is set.
- R8: Each slot load is one cycle with exactly one slot_load_o bit set. slot_pix_o carries the fetched row word, and slot_hpos_o and slot_hflip_o carry the descriptor's horizontal start and horizontal flip. No VRAM read happens in a load cycle.
- R9: Every slot is loaded exactly once per scan. Slots with no hit get slot_pix_o = 0, slot_hpos_o = 0 and slot_hflip_o = 0.
- R10: While rst_ni is low and after its release, the block is idle: no strobes and no reads until a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcnt_i | input | 10 | Physical horizontal counter, 0..799 |
| vcnt_i | input | 10 | Physical vertical counter, 0..524 |
| vram_rd_o | output | 1 | VRAM read enable |
| vram_addr_o | output | 11 | VRAM word address |
| vram_data_i | input | 32 | VRAM read data, one cycle after the read |
| slot_load_o | output | 8 | One-hot shifter slot load strobe |
| slot_pix_o | output | 32 | Row of eight 4-bit pixels for the strobed slot |
| slot_hpos_o | output | 9 | Horizontal start for the strobed slot |
| slot_hflip_o | output | 1 | Horizontal flip flag for the strobed slot |

## Verification
The assertions check on every cycle that:
- at most one slot strobe is high;
- strobes walk the slots in ascending order and stop after eight;
- no read overlaps a load;
- descriptor reads stay inside the 64-word table;
- VRAM is touched only inside the window that opens at logical column 320.

Only the bench scenarios can show the selection itself: which descriptors count as hits at the row boundaries, the vertically mirrored row, the early stop after eight hits, the transparent fill, and the line wrap at the last physical line. The bench shows these by comparing loaded slot contents against a model of the table walk.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       active;
    logic       hflip;
    logic       vflip;
    logic [6:0] idx;
    logic [8:0] hpos;
    logic [7:0] vpos;
  } spr_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC_RD,
    ST_DESC_EV,
    ST_ROW_RD,
    ST_ROW_LD,
    ST_FILL
  } ev_state_e;

endpackage

// File: rtl/spr_line_trigger.sv
module spr_line_trigger #(
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int H_TRIG  = 320,
  parameter int V_TOTAL = 525
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  output logic          trig_o,
  output logic [VW-2:0] line_o
);

  logic          hit_w;
  logic          hit_q;
  logic [VW-1:0] vnext_w;
  logic          unused_hlsb;

  assign unused_hlsb = hcnt_i[0];
  assign hit_w       = (hcnt_i[HW-1:1] == (HW-1)'(H_TRIG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_w;
  end

  assign trig_o  = hit_w & ~hit_q;
  assign vnext_w = (vcnt_i == VW'(V_TOTAL - 1)) ? '0 : vcnt_i + VW'(1);
  assign line_o  = vnext_w[VW-1:1];

endmodule

// File: rtl/spr_desc_match.sv
module spr_desc_match #(
  parameter int LINE_W = 9,
  parameter int VPOS_W = 8,
  parameter int IDX_W  = 7,
  parameter int ROWS   = 8,
  parameter int AW     = 11,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [VPOS_W-1:0] vpos_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              active_i,
  input  logic              vflip_i,
  output logic              hit_o,
  output logic [AW-1:0]     row_addr_o
);

  logic [LINE_W:0]  diff_w;
  logic [ROW_W-1:0] row_w;
  logic [ROW_W-1:0] row_eff_w;

  // underflow wraps to a large value and fails the span test
  assign diff_w    = {1'b0, line_i} - (LINE_W+1)'(vpos_i);
  assign hit_o     = active_i && (diff_w < (LINE_W+1)'(ROWS));
  assign row_w     = diff_w[ROW_W-1:0];
  assign row_eff_w = vflip_i ? (ROW_W'(ROWS - 1) - row_w) : row_w;
  assign row_addr_o = AW'({idx_i, row_eff_w});

endmodule

// File: rtl/spr_slot_demux.sv
module spr_slot_demux #(
  parameter int SLOTS   = 8,
  localparam int SEL_W  = $clog2(SLOTS)
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SLOTS-1:0] strobe_o
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign strobe_o[g] = en_i && (sel_i == SEL_W'(g));
  end

endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
  import spr_eval_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int DESCS     = 64,
  parameter int HW        = 10,
  parameter int VW        = 10,
  parameter int AW        = 11,
  parameter int DW        = 32,
  parameter int H_TRIG    = 320,
  parameter int V_TOTAL   = 525,
  parameter int DESC_BASE = 1024,
  parameter int ROWS      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HW-1:0]    hcnt_i,
  input  logic [VW-1:0]    vcnt_i,
  output logic             vram_rd_o,
  output logic [AW-1:0]    vram_addr_o,
  input  logic [DW-1:0]    vram_data_i,
  output logic [SLOTS-1:0] slot_load_o,
  output logic [DW-1:0]    slot_pix_o,
  output logic [8:0]       slot_hpos_o,
  output logic             slot_hflip_o
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DESC_W = $clog2(DESCS);
  localparam int LINE_W = VW - 1;

  ev_state_e         state_q;
  logic [DESC_W-1:0] desc_idx_q;
  logic [SLOT_W:0]   slot_q;
  logic [LINE_W-1:0] line_q;
  logic [8:0]        hpos_q;
  logic              hflip_q;
  logic [AW-1:0]     row_addr_q;

  logic              trig_w;
  logic [LINE_W-1:0] line_w;
  spr_desc_t         desc_w;
  logic              hit_w;
  logic [AW-1:0]     row_addr_w;
  logic              load_en_w;
  logic              last_desc_w;
  logic              last_slot_w;
  logic              unused_rsvd;

  assign desc_w      = spr_desc_t'(vram_data_i);
  assign unused_rsvd = ^desc_w.rsvd;
  assign last_desc_w = (desc_idx_q == DESC_W'(DESCS - 1));
  assign last_slot_w = (slot_q == (SLOT_W+1)'(SLOTS - 1));

  spr_line_trigger #(
    .HW(HW), .VW(VW), .H_TRIG(H_TRIG), .V_TOTAL(V_TOTAL)
  ) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hcnt_i (hcnt_i),
    .vcnt_i (vcnt_i),
    .trig_o (trig_w),
    .line_o (line_w)
  );

  spr_desc_match #(
    .LINE_W(LINE_W), .VPOS_W(8), .IDX_W(7), .ROWS(ROWS), .AW(AW)
  ) u_match (
    .line_i     (line_q),
    .vpos_i     (desc_w.vpos),
    .idx_i      (desc_w.idx),
    .active_i   (desc_w.active),
    .vflip_i    (desc_w.vflip),
    .hit_o      (hit_w),
    .row_addr_o (row_addr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      desc_idx_q <= '0;
      slot_q     <= '0;
      line_q     <= '0;
      hpos_q     <= '0;
      hflip_q    <= 1'b0;
      row_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_w) begin
            line_q     <= line_w;
            desc_idx_q <= '0;
            slot_q     <= '0;
            state_q    <= ST_DESC_RD;
          end
        end
        ST_DESC_RD: state_q <= ST_DESC_EV;
        ST_DESC_EV: begin
          if (hit_w) begin
            hpos_q     <= desc_w.hpos;
            hflip_q    <= desc_w.hflip;
            row_addr_q <= row_addr_w;
            state_q    <= ST_ROW_RD;
          end else if (last_desc_w) begin
            state_q <= ST_FILL;
          end else begin
            desc_idx_q <= desc_idx_q + DESC_W'(1);
            state_q    <= ST_DESC_RD;
          end
        end
        ST_ROW_RD: state_q <= ST_ROW_LD;
        ST_ROW_LD: begin
          slot_q <= slot_q + (SLOT_W+1)'(1);
          if (last_slot_w) begin
            state_q <= ST_IDLE;
          end else if (last_desc_w) begin
            state_q <= ST_FILL;
          end else begin
            desc_idx_q <= desc_idx_q + DESC_W'(1);
            state_q    <= ST_DESC_RD;
          end
        end
        ST_FILL: begin
          slot_q <= slot_q + (SLOT_W+1)'(1);
          if (last_slot_w) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    vram_rd_o   = 1'b0;
    vram_addr_o = row_addr_q;
    if (state_q == ST_DESC_RD) begin
      vram_rd_o   = 1'b1;
      vram_addr_o = AW'(DESC_BASE) + AW'(desc_idx_q);
    end else if (state_q == ST_ROW_RD) begin
      vram_rd_o = 1'b1;
    end
  end

  assign load_en_w = (state_q == ST_ROW_LD) || (state_q == ST_FILL);

  spr_slot_demux #(.SLOTS(SLOTS)) u_demux (
    .en_i     (load_en_w),
    .sel_i    (slot_q[SLOT_W-1:0]),
    .strobe_o (slot_load_o)
  );

  always_comb begin
    if (state_q == ST_ROW_LD) begin
      slot_pix_o   = vram_data_i;
      slot_hpos_o  = hpos_q;
      slot_hflip_o = hflip_q;
    end else begin
      slot_pix_o   = '0;
      slot_hpos_o  = '0;
      slot_hflip_o = 1'b0;
    end
  end

endmodule

// File: rtl/spr_eval_chk.sv
module spr_eval_chk #(
  parameter int SLOTS     = 8,
  parameter int DESCS     = 64,
  parameter int HW        = 10,
  parameter int AW        = 11,
  parameter int H_TRIG    = 320,
  parameter int DESC_BASE = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [HW-1:0]    hcnt_i,
  input logic             vram_rd_o,
  input logic [AW-1:0]    vram_addr_o,
  input logic [SLOTS-1:0] slot_load_o
);

  localparam int CNT_W = $clog2(SLOTS) + 1;

  logic             m_w;
  logic             m_q;
  logic             win_q;
  logic [CNT_W-1:0] ld_cnt_q;
  logic             any_ld_w;
  logic             unused_hlsb;

  assign unused_hlsb = hcnt_i[0];
  assign m_w         = (hcnt_i[HW-1:1] == (HW-1)'(H_TRIG));
  assign any_ld_w    = |slot_load_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q      <= 1'b0;
      win_q    <= 1'b0;
      ld_cnt_q <= '0;
    end else begin
      m_q <= m_w;
      if (!win_q && m_w && !m_q) begin
        win_q    <= 1'b1;
        ld_cnt_q <= '0;
      end else if (any_ld_w) begin
        ld_cnt_q <= ld_cnt_q + CNT_W'(1);
        if (ld_cnt_q == CNT_W'(SLOTS - 1)) win_q <= 1'b0;
      end
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_load_o)); // R8

  AST_LOAD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld_w |-> !vram_rd_o); // R8

  AST_DESC_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_rd_o && (vram_addr_o >= AW'(DESC_BASE))) |-> (vram_addr_o < AW'(DESC_BASE + DESCS))); // R3

  AST_READ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_rd_o || any_ld_w) |-> win_q); // R1

  AST_LOAD_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld_w |-> (slot_load_o == (SLOTS'(1) << ld_cnt_q))); // R6

  AST_LOAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld_w |-> (ld_cnt_q < CNT_W'(SLOTS))); // R9

endmodule

bind spr_line_eval spr_eval_chk #(
  .SLOTS(SLOTS), .DESCS(DESCS), .HW(HW), .AW(AW), .H_TRIG(H_TRIG), .DESC_BASE(DESC_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hcnt_i      (hcnt_i),
  .vram_rd_o   (vram_rd_o),
  .vram_addr_o (vram_addr_o),
  .slot_load_o (slot_load_o)
);

// File: tb/tb_spr_line_eval.sv
module tb_spr_line_eval;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  hcnt_i = '0;
  logic [9:0]  vcnt_i = '0;
  logic        vram_rd_o;
  logic [10:0] vram_addr_o;
  logic [31:0] vram_data_i;
  logic [7:0]  slot_load_o;
  logic [31:0] slot_pix_o;
  logic [8:0]  slot_hpos_o;
  logic        slot_hflip_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [2048];

  int          cap_n     [8];
  logic [31:0] cap_pix   [8];
  logic [8:0]  cap_hpos  [8];
  logic        cap_hflip [8];
  int          desc_reads;
  int          any_reads;

  logic [31:0] exp_pix   [8];
  logic [8:0]  exp_hpos  [8];
  logic        exp_hflip [8];
  int          exp_reads;

  // {vcnt, seed}
  localparam logic [17:0] VEC [6] = '{
    {10'd100, 8'd1}, {10'd0, 8'd2}, {10'd523, 8'd3},
    {10'd524, 8'd4}, {10'd300, 8'd5}, {10'd477, 8'd6}
  };

  always #10 clk_i = ~clk_i;

  spr_line_eval dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hcnt_i(hcnt_i), .vcnt_i(vcnt_i),
    .vram_rd_o(vram_rd_o), .vram_addr_o(vram_addr_o), .vram_data_i(vram_data_i),
    .slot_load_o(slot_load_o), .slot_pix_o(slot_pix_o),
    .slot_hpos_o(slot_hpos_o), .slot_hflip_o(slot_hflip_o)
  );

  always @(posedge clk_i) if (vram_rd_o) vram_data_i <= mem[vram_addr_o];

  always @(negedge clk_i) begin
    if (vram_rd_o) begin
      any_reads++;
      if (vram_addr_o >= 11'd1024) desc_reads++;
    end
    for (int s = 0; s < 8; s++) begin
      if (slot_load_o[s]) begin
        cap_n[s]++;
        cap_pix[s]   = slot_pix_o;
        cap_hpos[s]  = slot_hpos_o;
        cap_hflip[s] = slot_hflip_o;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_desc(int vpos, int hpos, int idx, bit vf, bit hf,
                                          bit act, int rsvd);
    return {rsvd[4:0], act, hf, vf, idx[6:0], hpos[8:0], vpos[7:0]};
  endfunction

  task automatic clear_desc();
    for (int k = 0; k < 64; k++) mem[1024 + k] = 32'h0;
  endtask

  task automatic clear_caps();
    for (int s = 0; s < 8; s++) begin
      cap_n[s] = 0; cap_pix[s] = 'x; cap_hpos[s] = 'x; cap_hflip[s] = 1'bx;
    end
    desc_reads = 0;
    any_reads  = 0;
  endtask

  // Reference walk built from R2, R4, R5, R6, R7, R9
  task automatic model(input int v);
    int y, n;
    n = 0;
    y = ((v == 524) ? 0 : v + 1) >> 1;
    exp_reads = 64;
    for (int s = 0; s < 8; s++) begin
      exp_pix[s] = 0; exp_hpos[s] = 0; exp_hflip[s] = 0;
    end
    for (int k = 0; k < 64 && n < 8; k++) begin
      logic [31:0] d;
      int vp, r;
      d  = mem[1024 + k];
      vp = int'(d[7:0]);
      if (d[26] && y >= vp && y - vp <= 7) begin
        r = y - vp;
        if (d[24]) r = 7 - r;
        exp_pix[n]   = mem[int'(d[23:17]) * 8 + r];
        exp_hpos[n]  = d[16:8];
        exp_hflip[n] = d[25];
        n++;
        if (n == 8) exp_reads = k + 1;
      end
    end
  endtask

  task automatic run_line(input int v);
    clear_caps();
    vcnt_i = 10'(v);
    for (int c = 0; c < 220; c++) begin
      @(posedge clk_i);
      #1 hcnt_i = 10'((630 + c) % 800);
    end
    @(posedge clk_i);
    #1 hcnt_i = 10'd0;
    repeat (2) @(posedge clk_i);
  endtask

  task automatic check_line(input string tag);
    for (int s = 0; s < 8; s++) begin
      chk({tag, " R9 slot loaded once"}, 32'(cap_n[s]), 32'd1);
      chk({tag, " R8 pix"},   cap_pix[s],          exp_pix[s]);
      chk({tag, " R8 hpos"},  32'(cap_hpos[s]),    32'(exp_hpos[s]));
      chk({tag, " R8 hflip"}, 32'(cap_hflip[s]),   32'(exp_hflip[s]));
    end
    chk({tag, " R6 R3 descriptor reads"}, 32'(desc_reads), 32'(exp_reads));
  endtask

  task automatic gen_table(input int seed, input int v);
    int y;
    y = ((v == 524) ? 0 : v + 1) >> 1;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] h, h2;
      h  = 32'(seed) * 32'd1103515245 + 32'(k) * 32'd2654435761 + 32'd12345;
      h  = h ^ (h << 13); h = h ^ (h >> 17); h = h ^ (h << 5);
      h2 = h * 32'd69069 + 32'd1;
      mem[1024 + k] = mk_desc((y + 2 - int'(h[3:0] % 12)) & 255, int'(h[23:15]),
                              int'(h[14:8]), h[24], h[25], h[27:26] != 2'b00,
                              int'(h2[31:27]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = (32'(a) * 32'h01000193) ^ 32'hA5A50001;
    clear_desc();
    clear_caps();
    repeat (4) @(posedge clk_i);
    #1;
    chk("R10 no strobe in reset", 32'(slot_load_o), 32'd0);
    chk("R10 no read in reset",   32'(vram_rd_o),   32'd0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 idle after reset", 32'(slot_load_o | 8'(vram_rd_o)), 32'd0);

    // table-driven random descriptor lines
    for (int i = 0; i < 6; i++) begin
      gen_table(int'(VEC[i][7:0]), int'(VEC[i][17:8]));
      model(int'(VEC[i][17:8]));
      run_line(int'(VEC[i][17:8]));
      check_line($sformatf("vec%0d", i));
    end

    // R1: counter away from column 320 starts nothing
    clear_caps();
    vcnt_i = 10'd99;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk_i);
      #1 hcnt_i = 10'(c * 2);
    end
    @(posedge clk_i); #1;
    chk("R1 no reads without trigger", 32'(any_reads), 32'd0);
    chk("R1 no strobes without trigger", 32'(cap_n[0] + cap_n[7]), 32'd0);

    // R5/R7/R4 boundaries at y = 50
    clear_desc();
    mem[1024 + 3]  = mk_desc(50, 17, 5, 0, 0, 1, 31);
    mem[1024 + 7]  = mk_desc(43, 2, 9, 1, 0, 1, 0);
    mem[1024 + 9]  = mk_desc(42, 3, 11, 0, 0, 1, 0);
    mem[1024 + 10] = mk_desc(51, 4, 12, 0, 0, 1, 0);
    mem[1024 + 12] = mk_desc(50, 5, 13, 0, 0, 0, 0);
    mem[1024 + 20] = mk_desc(47, 511, 127, 0, 1, 1, 0);
    run_line(99);
    chk("R5 R4 first row hit", cap_pix[0], mem[5 * 8 + 0]);
    chk("R4 hpos field", 32'(cap_hpos[0]), 32'd17);
    chk("R7 vflip last row maps to row 0", cap_pix[1], mem[9 * 8 + 0]);
    chk("R7 row 3 of index 127", cap_pix[2], mem[127 * 8 + 3]);
    chk("R8 hpos 511", 32'(cap_hpos[2]), 32'd511);
    chk("R8 hflip", 32'(cap_hflip[2]), 32'd1);
    chk("R5 miss and inactive skipped, R9 fill", cap_pix[3], 32'd0);
    model(99);
    check_line("boundary");

    // R6: more than eight hits
    clear_desc();
    for (int k = 2; k < 14; k++) mem[1024 + k] = mk_desc(50, k, k, 0, 0, 1, 0);
    mem[1024 + 63] = mk_desc(50, 1, 1, 0, 0, 1, 0);
    run_line(99);
    chk("R6 first eight slot0", cap_pix[0], mem[2 * 8]);
    chk("R6 first eight slot7", cap_pix[7], mem[9 * 8]);
    chk("R6 early stop reads", 32'(desc_reads), 32'd10);
    model(99);
    check_line("overflow");

    // R9: empty line after a full one
    clear_desc();
    run_line(99);
    model(99);
    check_line("empty");

    // R3: only the last entry hits
    mem[1024 + 63] = mk_desc(46, 8, 77, 0, 0, 1, 0);
    run_line(99);
    chk("R3 last entry reached", cap_pix[0], mem[77 * 8 + 4]);
    chk("R3 full table scanned", 32'(desc_reads), 32'd64);

    // R2: line wrap and odd/even mapping
    clear_desc();
    mem[1024] = mk_desc(0, 9, 1, 0, 0, 1, 0);
    run_line(524);
    chk("R2 vcnt 524 targets line 0", cap_pix[0], mem[8]);
    run_line(1);
    chk("R2 vcnt 1 targets line 1", cap_pix[0], mem[9]);
    run_line(523);
    chk("R2 vcnt 523 targets line 262 (no hit)", cap_pix[0], 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule